// File: doc/BRIEF.md
# Embedded-Clock Word Serializer with Training Burst

This block turns a 10-bit parallel word into a 12-bit serial frame and shifts it out one bit per clock. The design clock runs at the bit rate. An internal twelve-state counter marks the word boundaries. Each frame brackets the payload with a leading 1 and a trailing 0, and a receiver uses these two bits to recover the word clock. Frames follow each other with no gap, so the serial stream carries twelve bits per word period, ten of which are payload.

Two sync request inputs are ORed together. A request counts only after it has been seen high at six word boundaries in a row. It then replaces payload with a fixed training frame for a fixed number of frames, and keeps sending training frames for as long as the request stays high. An output-enable flag models the tri-state driver. That flag is true only when the enable input is high, the block is powered, no sync input is high and the start-up period is over. The power input stops the block, and on its return the block runs a start-up period of 1026 frames with the driver off. A select input chooses which edge of the word clock captures the parallel word.

Top module: `emb_clk_serializer`

## Requirements
- R1: Each frame occupies 12 consecutive serial bits: frame bit 0 is 1 (start), frame bits 1..10 carry word bits 0..9 in that order, and frame bit 11 is 0 (stop). Frame bit 0 appears on `serOut` in the cycle right after the `wordTick` cycle, and frames run back to back.
- R2: While powered, `wordTick` is high for one cycle in every 12. `wordClk` is high for the six cycles that follow a tick and low for the next six.
- R3: With `edgeSel`=1 the word is sampled at the clock edge that ends the `wordTick` cycle (the rising edge of `wordClk`) and goes into the frame that starts next. With `edgeSel`=0 it is sampled at the edge that ends the sixth cycle of a frame (the falling edge of `wordClk`) and goes into the following frame.
- R4: `syncReqA` and `syncReqB` are ORed and sampled at each word boundary. A request qualifies at the sixth consecutive high sample. Five high samples followed by a low one start no burst.
- R5: A qualified request sends exactly 1026 training frames, starting with the frame loaded at the qualifying boundary. Each training frame is six 1 bits followed by six 0 bits (frame bits 0..5 are 1, bits 6..11 are 0). `wordIn` is ignored during the burst, and payload resumes in the frame after the last training frame.
- R6: If the request is still high when the burst ends, training frames continue until the first word boundary at which the request is sampled low.
- R7: `driveEn` is high only when `outEnable`=1, `powerOn`=1, `syncReqA`=0, `syncReqB`=0 and the start-up period is over. `outEnable`=0 drops it at once.
- R8: While `powerOn`=0, `driveEn` and `wordTick` are 0 and `serOut` is 0 from the next cycle on. After reset, and whenever `powerOn` returns to 1, `driveEn` stays 0 through the first 1026 word ticks.
- R9: During reset, `serOut` and `driveEn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerOn | input | 1 | 1 = run, 0 = powered down |
| outEnable | input | 1 | Driver enable request |
| edgeSel | input | 1 | Word capture edge: 1 rising, 0 falling of `wordClk` |
| syncReqA | input | 1 | Sync request, ORed with `syncReqB` |
| syncReqB | input | 1 | Sync request, ORed with `syncReqA` |
| wordIn | input | 10 | Parallel payload word |
| serOut | output | 1 | Serial bit stream |
| driveEn | output | 1 | Serial driver enabled (low models high impedance) |
| wordTick | output | 1 | Last bit slot of a frame; the next frame loads at its end |
| wordClk | output | 1 | Derived word clock, high for the first half of each frame |

## Verification
The hardest case to reach is the end of a long training sequence. Telling the fixed 1026-frame burst apart from its extension under a held request takes over twelve thousand bit cycles of request timing aligned to word boundaries. The bench locks onto `wordTick` and collects whole frames back to back. It counts training frames exactly in two runs: one where the request drops right after qualifying, and one where it is held past the burst until a chosen count. In both runs it checks that the frame right after the last training frame carries live payload. A request held for only five boundaries checks the qualification threshold from the other side.

// File: rtl/ecs_pkg.sv
package ecs_pkg;
  typedef struct packed {
    logic loadFrame;    // load shift register at end of this cycle
    logic loadSync;     // load the training frame instead of payload
    logic captureHold;  // sample wordIn into the holding register
    logic useLive;      // frame payload taken from wordIn directly
    logic clearAll;     // powered down: clear datapath state
  } dpCtrl_t;
endpackage

// File: rtl/ecs_ctrl.sv
module ecs_ctrl
  import ecs_pkg::*;
#(
  parameter int FRAME_W      = 12,
  parameter int QUAL_WORDS   = 6,
  parameter int BURST_FRAMES = 1026,
  parameter int INIT_FRAMES  = 1026
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    powerOn,
  input  logic    outEnable,
  input  logic    edgeSel,
  input  logic    syncReqA,
  input  logic    syncReqB,
  output dpCtrl_t strobes,
  output logic    driveEn,
  output logic    wordTick,
  output logic    wordClk
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam int LAST  = FRAME_W - 1;
  localparam int MID   = FRAME_W / 2 - 1;
  localparam int QW    = $clog2(QUAL_WORDS + 1);
  localparam int BW    = $clog2(BURST_FRAMES + 1);
  localparam int IW    = $clog2(INIT_FRAMES + 1);

  logic [CNT_W-1:0] bitCnt;
  logic [QW-1:0]    reqRun;
  logic [BW-1:0]    burstLeft;
  logic [IW-1:0]    initLeft;

  logic syncReq, boundary, qualify, extend, sendSync;

  assign syncReq  = syncReqA | syncReqB;
  assign boundary = powerOn && (bitCnt == CNT_W'(LAST));
  // sixth consecutive high sample at a word boundary
  assign qualify  = boundary && syncReq && (reqRun == QW'(QUAL_WORDS - 1));
  // request still held after qualification: keep training
  assign extend   = syncReq && (reqRun == QW'(QUAL_WORDS));
  assign sendSync = qualify || (burstLeft != '0) || extend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= CNT_W'(LAST);
      reqRun    <= '0;
      burstLeft <= '0;
      initLeft  <= IW'(INIT_FRAMES);
    end else if (!powerOn) begin
      bitCnt    <= CNT_W'(LAST);
      reqRun    <= '0;
      burstLeft <= '0;
      initLeft  <= IW'(INIT_FRAMES);
    end else begin
      bitCnt <= boundary ? '0 : bitCnt + 1'b1;
      if (boundary) begin
        if (!syncReq)                      reqRun <= '0;
        else if (reqRun != QW'(QUAL_WORDS)) reqRun <= reqRun + 1'b1;

        if (qualify)                burstLeft <= BW'(BURST_FRAMES - 1);
        else if (burstLeft != '0)   burstLeft <= burstLeft - 1'b1;

        if (initLeft != '0)         initLeft <= initLeft - 1'b1;
      end
    end
  end

  always_comb begin
    strobes.loadFrame   = boundary;
    strobes.loadSync    = sendSync;
    strobes.captureHold = powerOn && (bitCnt == CNT_W'(MID));
    strobes.useLive     = edgeSel;
    strobes.clearAll    = !powerOn;
  end

  assign driveEn  = outEnable && powerOn && !syncReq && (initLeft == '0);
  assign wordTick = boundary;
  assign wordClk  = powerOn && (bitCnt <= CNT_W'(MID));
endmodule

// File: rtl/ecs_datapath.sv
module ecs_datapath
  import ecs_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           strobes,
  input  logic [DATA_W-1:0] wordIn,
  output logic              serOut
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int HALF    = FRAME_W / 2;
  localparam logic [FRAME_W-1:0] SYNC_FRAME =
    {{(FRAME_W - HALF){1'b0}}, {HALF{1'b1}}};

  logic [DATA_W-1:0]  holdWord;
  logic [FRAME_W-1:0] shiftReg;
  logic [DATA_W-1:0]  selWord;
  logic [FRAME_W-1:0] dataFrame;

  assign selWord   = strobes.useLive ? wordIn : holdWord;
  // LSB leaves first: start(1), word bit 0..9, stop(0)
  assign dataFrame = {1'b0, selWord, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      shiftReg <= '0;
    end else if (strobes.clearAll) begin
      holdWord <= '0;
      shiftReg <= '0;
    end else begin
      if (strobes.captureHold) holdWord <= wordIn;
      if (strobes.loadFrame)
        shiftReg <= strobes.loadSync ? SYNC_FRAME : dataFrame;
      else
        shiftReg <= {1'b0, shiftReg[FRAME_W-1:1]};
    end
  end

  assign serOut = shiftReg[0];
endmodule

// File: rtl/emb_clk_serializer.sv
module emb_clk_serializer
  import ecs_pkg::*;
#(
  parameter int DATA_W       = 10,
  parameter int QUAL_WORDS   = 6,
  parameter int BURST_FRAMES = 1026,
  parameter int INIT_FRAMES  = 1026
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerOn,
  input  logic              outEnable,
  input  logic              edgeSel,
  input  logic              syncReqA,
  input  logic              syncReqB,
  input  logic [DATA_W-1:0] wordIn,
  output logic              serOut,
  output logic              driveEn,
  output logic              wordTick,
  output logic              wordClk
);
  localparam int FRAME_W = DATA_W + 2;

  dpCtrl_t strobes;

  ecs_ctrl #(
    .FRAME_W(FRAME_W), .QUAL_WORDS(QUAL_WORDS),
    .BURST_FRAMES(BURST_FRAMES), .INIT_FRAMES(INIT_FRAMES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .powerOn(powerOn), .outEnable(outEnable),
    .edgeSel(edgeSel), .syncReqA(syncReqA), .syncReqB(syncReqB),
    .strobes(strobes), .driveEn(driveEn), .wordTick(wordTick),
    .wordClk(wordClk)
  );

  ecs_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wordIn(wordIn),
    .serOut(serOut)
  );
endmodule

// File: rtl/ecs_checker.sv
module ecs_checker #(
  parameter int FRAME_W = 12
) (
  input logic clk,
  input logic rstN,
  input logic powerOn,
  input logic outEnable,
  input logic syncReqA,
  input logic syncReqB,
  input logic serOut,
  input logic driveEn,
  input logic wordTick,
  input logic wordClk
);
  logic [7:0] sinceTick;
  logic       haveTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceTick <= '0;
      haveTick  <= 1'b0;
    end else if (wordTick) begin
      sinceTick <= 8'd1;
      haveTick  <= 1'b1;
    end else if (!powerOn) begin
      haveTick  <= 1'b0;
    end else begin
      sinceTick <= sinceTick + 8'd1;
    end
  end

  // R7: driver only on under the enabling input conditions
  a_r7_drive_gate: assert property (@(posedge clk) disable iff (!rstN)
    driveEn |-> (outEnable && powerOn && !syncReqA && !syncReqB));

  // R1: start bit follows every tick
  a_r1_start_bit: assert property (@(posedge clk) disable iff (!rstN)
    wordTick |=> (!powerOn || serOut));

  // R1: stop bit sits in the tick cycle
  a_r1_stop_bit: assert property (@(posedge clk) disable iff (!rstN)
    wordTick |-> !serOut);

  // R2: ticks twelve cycles apart
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (wordTick && haveTick) |-> (sinceTick == 8'(FRAME_W)));

  // R2: word clock rises after a tick
  a_r2_wordclk_rise: assert property (@(posedge clk) disable iff (!rstN)
    wordTick |=> (!powerOn || wordClk));

  // R8: powered down means quiet
  a_r8_pd_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !powerOn |-> (!driveEn && !wordTick));

  // R8: serial line cleared one cycle into power-down
  a_r8_pd_clear: assert property (@(posedge clk) disable iff (!rstN)
    !powerOn |=> !serOut);
endmodule

bind emb_clk_serializer ecs_checker #(.FRAME_W(DATA_W + 2)) u_chk (
  .clk(clk), .rstN(rstN), .powerOn(powerOn), .outEnable(outEnable),
  .syncReqA(syncReqA), .syncReqB(syncReqB), .serOut(serOut),
  .driveEn(driveEn), .wordTick(wordTick), .wordClk(wordClk)
);

// File: tb/emb_clk_serializer_tb.sv
`timescale 1ns/1ps
module emb_clk_serializer_tb;
  localparam logic [11:0] SYNC_F = 12'b000000_111111;
  localparam int NVEC = 9;
  // {edgeSel, word}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 10'h000}, {1'b1, 10'h3FF}, {1'b1, 10'h155}, {1'b1, 10'h2AA},
    {1'b0, 10'h0F3}, {1'b0, 10'h301}, {1'b1, 10'h201}, {1'b0, 10'h001},
    {1'b0, 10'h3C0}
  };

  logic clk = 1'b0;
  logic rstN, powerOn, outEnable, edgeSel, syncReqA, syncReqB;
  logic [9:0] wordIn;
  logic serOut, driveEn, wordTick, wordClk;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  emb_clk_serializer u_dut (
    .clk(clk), .rstN(rstN), .powerOn(powerOn), .outEnable(outEnable),
    .edgeSel(edgeSel), .syncReqA(syncReqA), .syncReqB(syncReqB),
    .wordIn(wordIn), .serOut(serOut), .driveEn(driveEn),
    .wordTick(wordTick), .wordClk(wordClk)
  );

  function automatic logic [11:0] dataFrame(input logic [9:0] w);
    return {1'b0, w, 1'b1};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // collect the 12 bits of the frame loaded at the current tick
  task automatic collect(output logic [11:0] f);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      f[i] = serOut;
    end
  endtask

  task automatic countInit(output int n);
    n = 0;
    #1;
    while (!driveEn) begin
      if (wordTick) n++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: act=timeout exp=finished");
    finishUp();
  end

  initial begin : main
    logic [11:0] f;
    logic [9:0]  prev;
    int n;

    rstN = 1'b0; powerOn = 1'b1; outEnable = 1'b1; edgeSel = 1'b1;
    syncReqA = 1'b0; syncReqB = 1'b0; wordIn = '0;
    repeat (3) @(negedge clk);
    chk(serOut == 1'b0, "R9 serOut in reset", int'(serOut), 0);
    chk(driveEn == 1'b0, "R9 driveEn in reset", int'(driveEn), 0);

    // R8: start-up period after reset
    rstN = 1'b1;
    countInit(n);
    chk(n == 1026, "R8 ticks before drive after reset", n, 1026);

    // R2: tick period and word clock shape
    do @(negedge clk); while (!wordTick);
    n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (wordClk) n++;
      if (i < 11) chk(!wordTick, "R2 no extra tick", int'(wordTick), 0);
    end
    chk(wordTick == 1'b1, "R2 tick after 12 cycles", int'(wordTick), 1);
    chk(n == 6, "R2 wordClk high cycles", n, 6);

    // R1/R3: vector table walked at frame boundaries
    prev = wordIn;
    for (int i = 0; i < NVEC; i++) begin
      logic [9:0] exp;
      edgeSel = VEC[i][10];
      wordIn  = VEC[i][9:0];
      exp = VEC[i][10] ? VEC[i][9:0] : prev;
      collect(f);
      chk(f == dataFrame(exp), "R1/R3 frame content", int'(f), int'(dataFrame(exp)));
      prev = VEC[i][9:0];
    end
    chk(driveEn == 1'b1, "R7 drive on in normal run", int'(driveEn), 1);

    // R7: enable low drops drive at once
    outEnable = 1'b0; #1;
    chk(driveEn == 1'b0, "R7 outEnable low", int'(driveEn), 0);
    outEnable = 1'b1; #1;
    chk(driveEn == 1'b1, "R7 outEnable high", int'(driveEn), 1);
    do @(negedge clk); while (!wordTick);

    // R4: five-boundary request does not qualify (via syncReqB)
    edgeSel = 1'b1; wordIn = 10'h1A5;
    syncReqB = 1'b1; #1;
    chk(driveEn == 1'b0, "R7 drive off while sync high", int'(driveEn), 0);
    for (int i = 0; i < 5; i++) collect(f);
    syncReqB = 1'b0;
    n = 0;
    for (int i = 0; i < 4; i++) begin
      collect(f);
      if (f != dataFrame(10'h1A5)) n++;
    end
    chk(n == 0, "R4 short request starts no burst", n, 0);

    // R4/R5: qualified request, dropped at once
    syncReqA = 1'b1;
    n = 0;
    for (int i = 0; i < 5; i++) begin
      collect(f);
      if (f != dataFrame(10'h1A5)) n++;
    end
    chk(n == 0, "R4 payload until qualification", n, 0);
    collect(f);
    chk(f == SYNC_F, "R4 training at sixth boundary", int'(f), int'(SYNC_F));
    syncReqA = 1'b0; #1;
    chk(driveEn == 1'b1, "R7 drive on during burst after drop", int'(driveEn), 1);
    n = 1;
    prev = '0;
    do begin
      prev = 10'(n * 37);
      wordIn = prev;
      collect(f);
      if (f == SYNC_F) n++;
    end while (f == SYNC_F && n < 3000);
    chk(n == 1026, "R5 training frame count", n, 1026);
    chk(f == dataFrame(prev), "R5 payload resumes", int'(f), int'(dataFrame(prev)));

    // R6: request held past the burst
    wordIn = 10'h0C3;
    syncReqA = 1'b1;
    for (int i = 0; i < 5; i++) collect(f);
    n = 0;
    do begin
      collect(f);
      if (f == SYNC_F) n++;
    end while (f == SYNC_F && n < 1030);
    chk(n == 1030, "R6 training continues while held", n, 1030);
    syncReqA = 1'b0;
    collect(f);
    chk(f == dataFrame(10'h0C3), "R6 stops when request drops", int'(f), int'(dataFrame(10'h0C3)));

    // R8: power-down and return
    powerOn = 1'b0;
    @(negedge clk);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (serOut || driveEn || wordTick) n++;
    end
    chk(n == 0, "R8 quiet while powered down", n, 0);
    powerOn = 1'b1;
    countInit(n);
    chk(n == 1026, "R8 ticks before drive after power-up", n, 1026);

    finishUp();
  end
endmodule